// File: doc/BRIEF.md
# Video Frame Timing Generator

This block paces a serial display link that runs in video mode. It counts the cycles of a frame and marks where each cycle sits. Horizontal spans are counted in link byte-clock cycles and vertical spans in whole lines. The order inside a frame is fixed: vertical sync, vertical back porch, active lines, vertical front porch. Each line opens with horizontal sync, then horizontal back porch. The rest of the programmed line time is one span that holds active pixels and front porch.

Downstream packet logic reads the region codes and the start and end pulses to decide what to send. It reads a low-power flag to learn when the lanes may idle. An acknowledge request asks for a bus turnaround at the end of a frame. All configuration comes in on static inputs. The block copies it into shadow registers only when a frame begins, so a frame in flight never sees a half-written setting.

Top module: `vidTimingGen`

## Requirements
- R1: While reset is held or `enable` is low, every output is 0. If `enable` is sampled low at a clock edge, all outputs are 0 from the second edge after it onward.
- R2: Inside a line, `hRegion` is 0 (sync) for the first `cfgHsa` cycles, 1 (back porch) for the next `cfgHbp` cycles, and 2 (active plus front porch) for the remaining cycles. A line lasts max(`cfgHline`, `cfgHsa`+`cfgHbp`, 1) cycles, so an active span that would be negative is clamped to zero.
- R3: Inside a frame, `vRegion` is 0 (sync) for `cfgVsa` lines, 1 (back porch) for `cfgVbp` lines, 2 (active) for the active lines, and 3 (front porch) for `cfgVfp` lines, in that order. A blanking region programmed to zero lines is skipped.
- R4: An active line count of zero is treated as one active line.
- R5: `lineStart` is high only in the first cycle of each line, and `lineEnd` is high only in the last cycle.
- R6: `frameStart` is high only in the first cycle of line 0, and `frameEnd` is high only in the last cycle of the last line. While `enable` stays high, a new frame starts in the cycle right after `frameEnd`.
- R7: `btaReq` pulses together with `frameEnd` when the frame's `cfgBtaEn` is 1, and it stays 0 otherwise.
- R8: `lpOk` follows the frame's low-power enables. In sync lines it follows bit 0, in back-porch lines bit 1, and in front-porch lines bit 2, for the whole line. In active lines it equals bit 3 during horizontal back porch and is 0 elsewhere.
- R9: `burstMode` holds the frame's `cfgBurst` value for every cycle of that frame.
- R10: Configuration inputs are sampled only when a frame begins, either on the edge that leaves idle or on the edge after the last cycle of a frame. A change made during a frame first shows in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the timing; low returns to idle |
| cfgHsa | input | HW | Horizontal sync cycles |
| cfgHbp | input | HW | Horizontal back porch cycles |
| cfgHline | input | HW | Total line cycles |
| cfgVsa | input | VW | Vertical sync lines |
| cfgVbp | input | VW | Vertical back porch lines |
| cfgVact | input | VW | Active lines |
| cfgVfp | input | VW | Vertical front porch lines |
| cfgLpEn | input | 4 | Low-power enables: [0] vsync, [1] vbp, [2] vfp, [3] hbp in active lines |
| cfgBtaEn | input | 1 | Request turnaround at frame end |
| cfgBurst | input | 1 | Burst (1) or non-burst (0) transfer |
| timingValid | output | 1 | Timing outputs are meaningful |
| hRegion | output | 2 | 0 sync, 1 back porch, 2 active plus front porch |
| vRegion | output | 2 | 0 sync, 1 back porch, 2 active, 3 front porch |
| lineStart | output | 1 | First cycle of a line |
| lineEnd | output | 1 | Last cycle of a line |
| frameStart | output | 1 | First cycle of a frame |
| frameEnd | output | 1 | Last cycle of a frame |
| btaReq | output | 1 | Turnaround request at frame end |
| lpOk | output | 1 | Low power allowed this cycle |
| burstMode | output | 1 | Frame's transfer mode |

## Verification
A bad horizontal counter or a bad span bound shows up within one line. Either `hRegion` changes on the wrong cycle, or `lineEnd` lands where the model does not expect it. A bad line counter or a bad shadow copy only surfaces at a region boundary or at the next frame, so the bench compares every output on every cycle across whole frames. It also applies new settings in the middle of a frame, which exposes any leak into the current frame at its first cycle. Broken back-to-back framing or a broken idle return shows within two cycles of `frameEnd` or of `enable` falling.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {H_SYNC = 2'd0, H_BP = 2'd1, H_ACTFP = 2'd2} hReg_e;
  typedef enum logic [1:0] {V_SYNC = 2'd0, V_BP = 2'd1, V_ACT = 2'd2, V_FP = 2'd3} vReg_e;

  // strobes from the sequencer to the counters
  typedef struct packed {
    logic run;
    logic load;
    logic incH;
    logic incLine;
  } ctlStrobe_t;

  // position flags returned by the counters
  typedef struct packed {
    logic lineLast;
    logic frameLast;
  } dpStatus_t;

endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb
);

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seqState_e;
  seqState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= enable ? S_RUN : S_IDLE;
  end

  always_comb begin
    strb         = '0;
    strb.run     = (state == S_RUN);
    strb.load    = enable && ((state == S_IDLE) || stat.frameLast);
    strb.incLine = strb.run && stat.lineLast && !stat.frameLast;
    strb.incH    = strb.run && !stat.lineLast;
  end

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strb,
  input  logic [HW-1:0] cfgHsa,
  input  logic [HW-1:0] cfgHbp,
  input  logic [HW-1:0] cfgHline,
  input  logic [VW-1:0] cfgVsa,
  input  logic [VW-1:0] cfgVbp,
  input  logic [VW-1:0] cfgVact,
  input  logic [VW-1:0] cfgVfp,
  input  logic [3:0]    cfgLpEn,
  input  logic          cfgBtaEn,
  input  logic          cfgBurst,
  output dpStatus_t     stat,
  output logic          validQ,
  output logic [1:0]    hRegQ,
  output logic [1:0]    vRegQ,
  output logic          lineStartQ,
  output logic          lineEndQ,
  output logic          frameStartQ,
  output logic          frameEndQ,
  output logic          btaQ,
  output logic          lpOkQ,
  output logic          burstQ
);

  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;

  // shadow configuration, loaded only at frame start
  logic [HCW-1:0] hsaQ, bpEndQ, lineLenQ;
  logic [VCW-1:0] vb1Q, vb2Q, vb3Q, frameLinesQ;
  logic [3:0]     lpEnQ;
  logic           btaEnQ, burstEnQ;

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] lineCnt;

  logic [HCW-1:0] bpEndD, lineLenD;
  logic [VCW-1:0] vactEff, vb1D, vb2D, vb3D, frameD;

  always_comb begin
    bpEndD   = HCW'(cfgHsa) + HCW'(cfgHbp);
    lineLenD = (HCW'(cfgHline) > bpEndD) ? HCW'(cfgHline) : bpEndD;
    if (lineLenD == '0) lineLenD = HCW'(1);
    vactEff  = (cfgVact == '0) ? VCW'(1) : VCW'(cfgVact);
    vb1D     = VCW'(cfgVsa);
    vb2D     = vb1D + VCW'(cfgVbp);
    vb3D     = vb2D + vactEff;
    frameD   = vb3D + VCW'(cfgVfp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsaQ <= '0; bpEndQ <= '0; lineLenQ <= HCW'(1);
      vb1Q <= '0; vb2Q <= '0; vb3Q <= '0; frameLinesQ <= VCW'(1);
      lpEnQ <= '0; btaEnQ <= 1'b0; burstEnQ <= 1'b0;
    end else if (strb.load) begin
      hsaQ <= HCW'(cfgHsa); bpEndQ <= bpEndD; lineLenQ <= lineLenD;
      vb1Q <= vb1D; vb2Q <= vb2D; vb3Q <= vb3D; frameLinesQ <= frameD;
      lpEnQ <= cfgLpEn; btaEnQ <= cfgBtaEn; burstEnQ <= cfgBurst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.load || !strb.run) begin
      hCnt    <= '0;
      lineCnt <= '0;
    end else if (strb.incLine) begin
      hCnt    <= '0;
      lineCnt <= lineCnt + VCW'(1);
    end else if (strb.incH) begin
      hCnt    <= hCnt + HCW'(1);
    end
  end

  always_comb begin
    stat.lineLast  = (hCnt == lineLenQ - HCW'(1));
    stat.frameLast = stat.lineLast && (lineCnt == frameLinesQ - VCW'(1));
  end

  hReg_e hNow;
  vReg_e vNow;
  logic  lpNow;

  always_comb begin
    if (hCnt < hsaQ)        hNow = H_SYNC;
    else if (hCnt < bpEndQ) hNow = H_BP;
    else                    hNow = H_ACTFP;
    if (lineCnt < vb1Q)      vNow = V_SYNC;
    else if (lineCnt < vb2Q) vNow = V_BP;
    else if (lineCnt < vb3Q) vNow = V_ACT;
    else                     vNow = V_FP;
    unique case (vNow)
      V_SYNC:  lpNow = lpEnQ[0];
      V_BP:    lpNow = lpEnQ[1];
      V_ACT:   lpNow = lpEnQ[3] && (hNow == H_BP);
      default: lpNow = lpEnQ[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) begin
      validQ <= 1'b0; hRegQ <= '0; vRegQ <= '0;
      lineStartQ <= 1'b0; lineEndQ <= 1'b0;
      frameStartQ <= 1'b0; frameEndQ <= 1'b0;
      btaQ <= 1'b0; lpOkQ <= 1'b0; burstQ <= 1'b0;
    end else begin
      validQ      <= 1'b1;
      hRegQ       <= hNow;
      vRegQ       <= vNow;
      lineStartQ  <= (hCnt == '0);
      lineEndQ    <= stat.lineLast;
      frameStartQ <= (hCnt == '0) && (lineCnt == '0);
      frameEndQ   <= stat.frameLast;
      btaQ        <= stat.frameLast && btaEnQ;
      lpOkQ       <= lpNow;
      burstQ      <= burstEnQ;
    end
  end

  // counters never run past the shadowed line and frame lengths
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (hCnt < lineLenQ) && (lineCnt < frameLinesQ));

  // shadow values move only on a frame-start load
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(lineLenQ) && $stable(frameLinesQ) && $stable(vb3Q));

endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [HW-1:0] cfgHsa,
  input  logic [HW-1:0] cfgHbp,
  input  logic [HW-1:0] cfgHline,
  input  logic [VW-1:0] cfgVsa,
  input  logic [VW-1:0] cfgVbp,
  input  logic [VW-1:0] cfgVact,
  input  logic [VW-1:0] cfgVfp,
  input  logic [3:0]    cfgLpEn,
  input  logic          cfgBtaEn,
  input  logic          cfgBurst,
  output logic          timingValid,
  output logic [1:0]    hRegion,
  output logic [1:0]    vRegion,
  output logic          lineStart,
  output logic          lineEnd,
  output logic          frameStart,
  output logic          frameEnd,
  output logic          btaReq,
  output logic          lpOk,
  output logic          burstMode
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  vtg_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .stat   (stat),
    .strb   (strb)
  );

  vtg_datapath #(.HW(HW), .VW(VW)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgHsa      (cfgHsa),
    .cfgHbp      (cfgHbp),
    .cfgHline    (cfgHline),
    .cfgVsa      (cfgVsa),
    .cfgVbp      (cfgVbp),
    .cfgVact     (cfgVact),
    .cfgVfp      (cfgVfp),
    .cfgLpEn     (cfgLpEn),
    .cfgBtaEn    (cfgBtaEn),
    .cfgBurst    (cfgBurst),
    .stat        (stat),
    .validQ      (timingValid),
    .hRegQ       (hRegion),
    .vRegQ       (vRegion),
    .lineStartQ  (lineStart),
    .lineEndQ    (lineEnd),
    .frameStartQ (frameStart),
    .frameEndQ   (frameEnd),
    .btaQ        (btaReq),
    .lpOkQ       (lpOk),
    .burstQ      (burstMode)
  );

  // a frame end is followed directly by the next frame start
  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd && $past(enable) |=> frameStart);

  // a line end inside a frame is followed by a line start
  assert_line_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd && !frameEnd && $past(enable) |=> lineStart);

  // two low enable samples leave the outputs quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) && !$past(enable, 2) |-> !timingValid && !frameStart && !lpOk);

endmodule

// File: tb/vidTimingGen_test.sv
module vidTimingGen_test;

  localparam int HW = 12;
  localparam int VW = 11;

  typedef struct {
    int hsa, hbp, hline, vsa, vbp, vact, vfp;
    logic [3:0] lp;
    logic bta, burst;
  } cfg_t;

  logic clk = 1'b0;
  logic rstN, enable;
  logic [HW-1:0] cfgHsa, cfgHbp, cfgHline;
  logic [VW-1:0] cfgVsa, cfgVbp, cfgVact, cfgVfp;
  logic [3:0] cfgLpEn;
  logic cfgBtaEn, cfgBurst;
  logic timingValid, lineStart, lineEnd, frameStart, frameEnd, btaReq, lpOk, burstMode;
  logic [1:0] hRegion, vRegion;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vidTimingGen #(.HW(HW), .VW(VW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgHsa(cfgHsa), .cfgHbp(cfgHbp), .cfgHline(cfgHline),
    .cfgVsa(cfgVsa), .cfgVbp(cfgVbp), .cfgVact(cfgVact), .cfgVfp(cfgVfp),
    .cfgLpEn(cfgLpEn), .cfgBtaEn(cfgBtaEn), .cfgBurst(cfgBurst),
    .timingValid(timingValid), .hRegion(hRegion), .vRegion(vRegion),
    .lineStart(lineStart), .lineEnd(lineEnd), .frameStart(frameStart),
    .frameEnd(frameEnd), .btaReq(btaReq), .lpOk(lpOk), .burstMode(burstMode)
  );

  function automatic int lineLen(cfg_t c);
    int l = c.hline;
    if (c.hsa + c.hbp > l) l = c.hsa + c.hbp;
    if (l < 1) l = 1;
    return l;
  endfunction

  function automatic int actLines(cfg_t c);
    return (c.vact == 0) ? 1 : c.vact;
  endfunction

  function automatic int frameLines(cfg_t c);
    return c.vsa + c.vbp + actLines(c) + c.vfp;
  endfunction

  // expected {valid,h,v,ls,le,fs,fe,bta,lp,burst} at line l, cycle h
  function automatic logic [11:0] expVec(cfg_t c, int l, int h);
    logic [1:0] hr, vr;
    logic lp, fe;
    int len = lineLen(c);
    if (h < c.hsa) hr = 2'd0;
    else if (h < c.hsa + c.hbp) hr = 2'd1;
    else hr = 2'd2;
    if (l < c.vsa) vr = 2'd0;
    else if (l < c.vsa + c.vbp) vr = 2'd1;
    else if (l < c.vsa + c.vbp + actLines(c)) vr = 2'd2;
    else vr = 2'd3;
    case (vr)
      2'd0: lp = c.lp[0];
      2'd1: lp = c.lp[1];
      2'd2: lp = c.lp[3] && (hr == 2'd1);
      default: lp = c.lp[2];
    endcase
    fe = (l == frameLines(c) - 1) && (h == len - 1);
    return {1'b1, hr, vr, h == 0, h == len - 1, (l == 0) && (h == 0), fe, fe && c.bta, lp, c.burst};
  endfunction

  function automatic logic [11:0] actVec();
    return {timingValid, hRegion, vRegion, lineStart, lineEnd, frameStart, frameEnd,
            btaReq, lpOk, burstMode};
  endfunction

  function automatic string tagOf(logic [11:0] d);
    if (d[11])          return "R1";
    if (d[10:9] != 0)   return "R2";
    if (d[8:7] != 0)    return "R3";
    if (d[6:5] != 0)    return "R5";
    if (d[4:3] != 0)    return "R6";
    if (d[2])           return "R7";
    if (d[1])           return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic applyCfg(cfg_t c);
    cfgHsa = HW'(c.hsa); cfgHbp = HW'(c.hbp); cfgHline = HW'(c.hline);
    cfgVsa = VW'(c.vsa); cfgVbp = VW'(c.vbp); cfgVact = VW'(c.vact); cfgVfp = VW'(c.vfp);
    cfgLpEn = c.lp; cfgBtaEn = c.bta; cfgBurst = c.burst;
  endtask

  function automatic cfg_t mk(int hsa, int hbp, int hline, int vsa, int vbp, int vact, int vfp,
                              logic [3:0] lp, logic bta, logic burst);
    cfg_t c;
    c.hsa = hsa; c.hbp = hbp; c.hline = hline; c.vsa = vsa; c.vbp = vbp;
    c.vact = vact; c.vfp = vfp; c.lp = lp; c.bta = bta; c.burst = burst;
    return c;
  endfunction

  function automatic cfg_t randCfg();
    cfg_t c;
    c = mk(int'($urandom % 5), int'($urandom % 5), int'($urandom % 20),
           int'($urandom % 4), int'($urandom % 4), int'($urandom % 6), int'($urandom % 4),
           4'($urandom), 1'($urandom), 1'($urandom));
    if (lineLen(c) * frameLines(c) < 2) c.vfp = 1;
    return c;
  endfunction

  // wait for frame start, load next settings mid-frame, then check every cycle
  task automatic runFrame(cfg_t active, cfg_t nxt, bit expectImmediate);
    int waited = 0;
    while (!frameStart && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    if (expectImmediate)
      check("R6 back-to-back", {11'd0, waited == 0}, 12'd1);
    applyCfg(nxt);  // R10: must not affect this frame
    for (int l = 0; l < frameLines(active); l++) begin
      for (int h = 0; h < lineLen(active); h++) begin
        logic [11:0] e = expVec(active, l, h);
        logic [11:0] a = actVec();
        check(tagOf(a ^ e), a, e);
        @(negedge clk);
      end
    end
  endtask

  function automatic string summary();
    return $sformatf("  %0d/%0d checks passed", checks - fails, checks);
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%s", summary());
    $finish;
  end

  initial begin
    cfg_t dir[6];
    cfg_t cur, nxt;
    void'($urandom(32'd4711));
    // R2 clamp: line shorter than sync+bp; R4 zero active lines; R3 skipped regions
    dir[0] = mk(3, 2, 12, 2, 1, 3, 2, 4'b1011, 1'b1, 1'b0);
    dir[1] = mk(4, 3, 5, 1, 2, 2, 1, 4'b0101, 1'b0, 1'b1);   // R2 clamp
    dir[2] = mk(2, 2, 8, 1, 1, 0, 1, 4'b1111, 1'b1, 1'b1);   // R4 vact 0
    dir[3] = mk(0, 0, 0, 1, 0, 0, 0, 4'b0001, 1'b1, 1'b0);   // one-cycle lines
    dir[4] = mk(1, 3, 10, 0, 0, 4, 0, 4'b1000, 1'b0, 1'b0);  // R3 no blanking lines
    dir[5] = mk(0, 2, 6, 0, 3, 1, 2, 4'b0110, 1'b1, 1'b1);

    rstN = 1'b0; enable = 1'b0;
    applyCfg(dir[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset", actVec(), 12'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle", actVec(), 12'd0);

    enable = 1'b1;
    cur = dir[0];
    for (int f = 0; f < 26; f++) begin
      nxt = (f + 1 < 6) ? dir[f + 1] : randCfg();
      runFrame(cur, nxt, f > 0);
      cur = nxt;
    end

    // R1: drop enable in the middle of a frame
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 disable", actVec(), 12'd0);
    repeat (5) @(negedge clk);
    check("R1 stays idle", actVec(), 12'd0);

    // R10: restart loads the settings present at the enable edge
    cur = dir[5];
    applyCfg(cur);
    enable = 1'b1;
    runFrame(cur, dir[2], 1'b0);
    runFrame(dir[2], dir[2], 1'b1);

    $display("%s", summary());
    $finish;
  end

endmodule